// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block owns the stack pointer of an 8051-style core whose stack can grow from 8 to 10 bits. It holds an 8-bit pointer and a small extension register that supplies the upper address bits. It serves four kinds of request: push a byte, pop a byte, call (push a return address) and return (pop a return address). For each one it drives a byte-wide memory port. Software can load the pointer, the extension register and two mode registers through a simple write port, and all four registers are visible on outputs.

A mode register holds two control bits. Bit 2 selects the 10-bit stack, and bit 1 selects 24-bit flat addressing, which makes calls and returns move three bytes instead of two. A second mode register carries a two-bit memory-mode field in bits 7:6. The unit never lets that field be 2'b11 while the 10-bit stack is enabled.

The sequencer is a state machine with seven states. S_IDLE accepts requests. S_POP_RESP returns popped data. S_CALL_HI and S_CALL_EX push the second and third return bytes. S_RET_MID, S_RET_LAST and S_RET_END collect the return bytes. The transitions are:
- S_IDLE goes to S_CALL_HI on a call.
- S_IDLE goes to S_RET_MID on a flat return, or to S_RET_LAST on a 16-bit return.
- S_IDLE goes to S_POP_RESP on a pop, and stays in S_IDLE on a push.
- S_CALL_HI goes to S_CALL_EX in flat mode, otherwise back to S_IDLE.
- S_RET_MID goes to S_RET_LAST, and S_RET_LAST goes to S_RET_END.
- S_CALL_EX, S_RET_END and S_POP_RESP return to S_IDLE.

Top module: `xstack_unit`

## Requirements
- R1: After reset the pointer is 7, the extension register and both mode registers are 0, and busy is 0.
- R2: A push accepted in S_IDLE raises mem_we in the same cycle, with mem_wdata equal to push_data and mem_addr equal to the incremented pointer. The pointer reads one higher from the next cycle.
- R3: With mode bit 2 set, the address is extension*256 + pointer. When a push wraps the pointer from 0xFF to 0x00, the extension increments modulo 4. When a pop takes the pointer from 0x00 to 0xFF, the extension decrements modulo 4.
- R4: With mode bit 2 clear, the address is the pointer with its upper bits 0, the pointer wraps modulo 256, and pushes and pops leave the extension unchanged.
- R5: A pop raises mem_re at the current address and decrements the pointer at that edge. In the next cycle pop_valid is 1 and pop_data equals mem_rdata.
- R6: A call pushes return-address bits 7:0, then 15:8, then (in flat mode, mode bit 1) bits 23:16, one per cycle. pc_load pulses during the last of these pushes.
- R7: The call target on pc_target has its upper byte forced to 0 when flat mode is off, or when call_irq is set. Otherwise it is the full call_target.
- R8: A return pops the bytes in reverse order: in flat mode the upper byte, then the high byte, then the low byte. One cycle after the last read, pc_load pulses with the reassembled address, whose upper byte is 0 when flat mode is off.
- R9: reg_sel codes are 00 pointer, 01 extension, 10 address-mode register, 11 memory-mode register. The extension keeps only reg_wdata[1:0], and ext_out bits 7:2 read 0.
- R10: A write to the address-mode register with bit 2 set, made while the memory-mode bits 7:6 are 2'b11, stores bit 2 as 0.
- R11: A write to the memory-mode register made while address-mode bit 2 is set stores bits 7:6 as 0.
- R12: Requests raised together in S_IDLE are served in the order call, return, push, pop. Only one is taken, and mem_we and mem_re are never high together.
- R13: While busy is 1 (any state other than S_IDLE), requests and register writes are ignored.
- R14: A register write in the same cycle that a request is accepted is dropped, and the request proceeds under the old register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_req | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop request |
| call_req | input | 1 | Call request |
| call_irq | input | 1 | Call is interrupt-driven |
| call_ret_addr | input | 24 | Return address to save |
| call_target | input | 24 | Destination of the call |
| ret_req | input | 1 | Return request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| mem_addr | output | 10 | Stack memory address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_wdata | output | 8 | Stack memory write data |
| mem_re | output | 1 | Stack memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| pop_valid | output | 1 | Popped byte is on pop_data |
| pop_data | output | 8 | Popped byte |
| pc_load | output | 1 | pc_target is valid |
| pc_target | output | 24 | New program counter |
| busy | output | 1 | Sequencer outside S_IDLE |
| sp_out | output | 8 | Pointer |
| ext_out | output | 8 | Extension register, zero-extended |
| actrl_out | output | 8 | Address-mode register |
| mctrl_out | output | 8 | Memory-mode register |

## Verification
A register write can land in the same cycle that a stack request is accepted, which makes the pointer movement and the software load compete for the same register. The bench provokes this in two ways. It issues a call with a pointer write, a push and a pop held high for the whole sequence. It also issues a push together with a mode write in 10-bit mode at pointer 0xFF. It judges the outcome at the ports: the pointer and extension must show only the request's movement, the push address must use the old mode, and the mode register must keep its old value.

// File: rtl/xstk_pkg.sv
package xstk_pkg;
    localparam int BYTE_W   = 8;
    localparam int PC_BYTES = 3;
    localparam int PC_W     = BYTE_W * PC_BYTES;

    localparam int AMODE_FLAT_BIT = 1;
    localparam int AMODE_WIDE_BIT = 2;
    localparam int MMODE_HI_BIT   = 7;
    localparam int MMODE_LO_BIT   = 6;

    typedef enum logic [1:0] {
        SEL_SP    = 2'b00,
        SEL_EXT   = 2'b01,
        SEL_AMODE = 2'b10,
        SEL_MMODE = 2'b11
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POP_RESP,
        S_CALL_HI,
        S_CALL_EX,
        S_RET_MID,
        S_RET_LAST,
        S_RET_END
    } seq_state_e;
endpackage

// File: rtl/xstk_ptr.sv
module xstk_ptr
    import xstk_pkg::*;
#(
    parameter int               EXT_W  = 2,
    parameter logic [BYTE_W-1:0] SP_RST = 8'd7,
    localparam int              ADDR_W = BYTE_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              inc,
    input  logic              dec,
    input  logic              wr_sp,
    input  logic              wr_ext,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] sp_q,
    output logic [EXT_W-1:0]  ext_q,
    output logic [ADDR_W-1:0] addr_cur,
    output logic [ADDR_W-1:0] addr_inc
);
    logic [BYTE_W-1:0] sp_plus, sp_minus;
    logic [EXT_W-1:0]  ext_up, ext_dn;
    logic              sp_top, sp_bot;

    always_comb begin
        sp_top   = (sp_q == {BYTE_W{1'b1}});
        sp_bot   = (sp_q == {BYTE_W{1'b0}});
        sp_plus  = sp_q + BYTE_W'(1);
        sp_minus = sp_q - BYTE_W'(1);
        ext_up   = (wide && sp_top) ? ext_q + EXT_W'(1) : ext_q;
        ext_dn   = (wide && sp_bot) ? ext_q - EXT_W'(1) : ext_q;
        addr_cur = wide ? {ext_q, sp_q} : {{EXT_W{1'b0}}, sp_q};
        addr_inc = wide ? {ext_up, sp_plus} : {{EXT_W{1'b0}}, sp_plus};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q  <= SP_RST;
            ext_q <= '0;
        end else if (inc) begin
            sp_q  <= sp_plus;
            ext_q <= ext_up;
        end else if (dec) begin
            sp_q  <= sp_minus;
            ext_q <= ext_dn;
        end else begin
            if (wr_sp)  sp_q  <= wdata;
            if (wr_ext) ext_q <= wdata[EXT_W-1:0];
        end
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> (sp_q == $past(sp_q) + BYTE_W'(1)));                       // R2
    AST_WIDE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && wide && sp_q == {BYTE_W{1'b1}}) |=> (ext_q == $past(ext_q) + EXT_W'(1))); // R3
    AST_WIDE_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && wide && sp_q == {BYTE_W{1'b0}}) |=> (ext_q == $past(ext_q) - EXT_W'(1))); // R3
    AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !wr_ext) |=> $stable(ext_q));                                        // R4
endmodule

// File: rtl/xstk_modes.sv
module xstk_modes
    import xstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_amode,
    input  logic              wr_mmode,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] amode_q,
    output logic [BYTE_W-1:0] mmode_q
);
    logic [BYTE_W-1:0] amode_d, mmode_d;
    logic              mm_both;

    always_comb begin
        mm_both = mmode_q[MMODE_HI_BIT] && mmode_q[MMODE_LO_BIT];
        amode_d = wdata;
        if (wdata[AMODE_WIDE_BIT] && mm_both)
            amode_d[AMODE_WIDE_BIT] = 1'b0;
        mmode_d = wdata;
        if (amode_q[AMODE_WIDE_BIT]) begin
            mmode_d[MMODE_HI_BIT] = 1'b0;
            mmode_d[MMODE_LO_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amode_q <= '0;
            mmode_q <= '0;
        end else begin
            if (wr_amode) amode_q <= amode_d;
            if (wr_mmode) mmode_q <= mmode_d;
        end
    end

    AST_NO_DUAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(amode_q[AMODE_WIDE_BIT] && mmode_q[MMODE_HI_BIT] && mmode_q[MMODE_LO_BIT])); // R10
    AST_MMODE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mmode && amode_q[AMODE_WIDE_BIT]) |=> (mmode_q[MMODE_HI_BIT:MMODE_LO_BIT] == 2'b00)); // R11
endmodule

// File: rtl/xstk_seq.sv
module xstk_seq
    import xstk_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flat,
    input  logic              push_req,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic              call_irq,
    input  logic [PC_W-1:0]   call_ret_addr,
    input  logic [PC_W-1:0]   call_target,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] addr_cur,
    input  logic [ADDR_W-1:0] addr_inc,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              inc,
    output logic              dec,
    output logic              op_start,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_target
);
    seq_state_e        st, nxt;
    logic [PC_W-1:0]   lat_ret, lat_tgt;
    logic              lat_irq, lat_flat;
    logic [BYTE_W-1:0] cap_x, cap_h;
    logic [PC_W-1:0]   call_pc, ret_pc;
    logic              any_req;

    assign any_req = call_req || ret_req || push_req || pop_req;

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: begin
                if (call_req)      nxt = S_CALL_HI;
                else if (ret_req)  nxt = flat ? S_RET_MID : S_RET_LAST;
                else if (push_req) nxt = S_IDLE;
                else if (pop_req)  nxt = S_POP_RESP;
            end
            S_POP_RESP: nxt = S_IDLE;
            S_CALL_HI:  nxt = lat_flat ? S_CALL_EX : S_IDLE;
            S_CALL_EX:  nxt = S_IDLE;
            S_RET_MID:  nxt = S_RET_LAST;
            S_RET_LAST: nxt = S_RET_END;
            S_RET_END:  nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // latched operands and captured return bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_ret  <= '0;
            lat_tgt  <= '0;
            lat_irq  <= 1'b0;
            lat_flat <= 1'b0;
            cap_x    <= '0;
            cap_h    <= '0;
        end else begin
            if (st == S_IDLE && call_req) begin
                lat_ret  <= call_ret_addr;
                lat_tgt  <= call_target;
                lat_irq  <= call_irq;
                lat_flat <= flat;
            end else if (st == S_IDLE && ret_req) begin
                lat_irq  <= 1'b0;
                lat_flat <= flat;
            end
            if (st == S_RET_MID)  cap_x <= mem_rdata;
            if (st == S_RET_LAST) cap_h <= mem_rdata;
        end
    end

    always_comb begin
        call_pc = {(lat_flat && !lat_irq) ? lat_tgt[PC_W-1:2*BYTE_W] : {BYTE_W{1'b0}},
                   lat_tgt[2*BYTE_W-1:0]};
        ret_pc  = {(lat_flat ? cap_x : {BYTE_W{1'b0}}), cap_h, mem_rdata};
    end

    // outputs
    always_comb begin
        inc       = 1'b0;
        dec       = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = addr_cur;
        mem_wdata = '0;
        pop_valid = 1'b0;
        pop_data  = '0;
        pc_load   = 1'b0;
        pc_target = '0;
        op_start  = (st == S_IDLE) && any_req;
        busy      = (st != S_IDLE);
        unique case (st)
            S_IDLE: begin
                if (call_req) begin
                    inc       = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = addr_inc;
                    mem_wdata = call_ret_addr[BYTE_W-1:0];
                end else if (ret_req || (!push_req && pop_req)) begin
                    dec      = 1'b1;
                    mem_re   = 1'b1;
                    mem_addr = addr_cur;
                end else if (push_req) begin
                    inc       = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = addr_inc;
                    mem_wdata = push_data;
                end
            end
            S_POP_RESP: begin
                pop_valid = 1'b1;
                pop_data  = mem_rdata;
            end
            S_CALL_HI: begin
                inc       = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_inc;
                mem_wdata = lat_ret[2*BYTE_W-1:BYTE_W];
                if (!lat_flat) begin
                    pc_load   = 1'b1;
                    pc_target = call_pc;
                end
            end
            S_CALL_EX: begin
                inc       = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_inc;
                mem_wdata = lat_ret[PC_W-1:2*BYTE_W];
                pc_load   = 1'b1;
                pc_target = call_pc;
            end
            S_RET_MID, S_RET_LAST: begin
                dec      = 1'b1;
                mem_re   = 1'b1;
                mem_addr = addr_cur;
            end
            S_RET_END: begin
                pc_load   = 1'b1;
                pc_target = ret_pc;
            end
            default: begin
                inc = 1'b0;
            end
        endcase
    end

    AST_POP_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && pop_req && !call_req && !ret_req && !push_req) |=> pop_valid); // R5
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));                                                          // R12
    AST_IRQ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && lat_irq && (st == S_CALL_HI || st == S_CALL_EX))
            |-> (pc_target[PC_W-1:2*BYTE_W] == {BYTE_W{1'b0}}));                      // R7
    AST_CALL_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && call_req) |=> (mem_we && busy));                              // R6
endmodule

// File: rtl/xstack_unit.sv
module xstack_unit
    import xstk_pkg::*;
#(
    parameter int               EXT_W  = 2,
    parameter logic [BYTE_W-1:0] SP_RST = 8'd7,
    localparam int              ADDR_W = BYTE_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic              call_irq,
    input  logic [PC_W-1:0]   call_ret_addr,
    input  logic [PC_W-1:0]   call_target,
    input  logic              ret_req,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_data,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_target,
    output logic              busy,
    output logic [BYTE_W-1:0] sp_out,
    output logic [BYTE_W-1:0] ext_out,
    output logic [BYTE_W-1:0] actrl_out,
    output logic [BYTE_W-1:0] mctrl_out
);
    logic              inc, dec, op_start, wr_ok;
    logic              wr_sp, wr_ext, wr_amode, wr_mmode;
    logic [BYTE_W-1:0] sp_q, amode_q, mmode_q;
    logic [EXT_W-1:0]  ext_q;
    logic [ADDR_W-1:0] addr_cur, addr_inc;

    always_comb begin
        wr_ok    = reg_wr && !busy && !op_start;
        wr_sp    = wr_ok && (reg_sel == SEL_SP);
        wr_ext   = wr_ok && (reg_sel == SEL_EXT);
        wr_amode = wr_ok && (reg_sel == SEL_AMODE);
        wr_mmode = wr_ok && (reg_sel == SEL_MMODE);
    end

    xstk_ptr #(.EXT_W(EXT_W), .SP_RST(SP_RST)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (amode_q[AMODE_WIDE_BIT]),
        .inc      (inc),
        .dec      (dec),
        .wr_sp    (wr_sp),
        .wr_ext   (wr_ext),
        .wdata    (reg_wdata),
        .sp_q     (sp_q),
        .ext_q    (ext_q),
        .addr_cur (addr_cur),
        .addr_inc (addr_inc)
    );

    xstk_modes u_modes (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_amode (wr_amode),
        .wr_mmode (wr_mmode),
        .wdata    (reg_wdata),
        .amode_q  (amode_q),
        .mmode_q  (mmode_q)
    );

    xstk_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .flat          (amode_q[AMODE_FLAT_BIT]),
        .push_req      (push_req),
        .push_data     (push_data),
        .pop_req       (pop_req),
        .call_req      (call_req),
        .call_irq      (call_irq),
        .call_ret_addr (call_ret_addr),
        .call_target   (call_target),
        .ret_req       (ret_req),
        .addr_cur      (addr_cur),
        .addr_inc      (addr_inc),
        .mem_rdata     (mem_rdata),
        .inc           (inc),
        .dec           (dec),
        .op_start      (op_start),
        .busy          (busy),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_re        (mem_re),
        .pop_valid     (pop_valid),
        .pop_data      (pop_data),
        .pc_load       (pc_load),
        .pc_target     (pc_target)
    );

    always_comb begin
        sp_out    = sp_q;
        ext_out   = {{(BYTE_W-EXT_W){1'b0}}, ext_q};
        actrl_out = amode_q;
        mctrl_out = mmode_q;
    end

    AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && reg_wr) |=> ($stable(amode_q) && $stable(mmode_q)));            // R14
    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inc && !dec) |=> ($stable(sp_q) && $stable(ext_q)));               // R13
endmodule

// File: tb/xstack_unit_tb_top.sv
`timescale 1ns/1ps
module xstack_unit_tb_top;
    import xstk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 0, pop_req = 0, call_req = 0, call_irq = 0, ret_req = 0, reg_wr = 0;
    logic [7:0]  push_data = 0, reg_wdata = 0;
    logic [1:0]  reg_sel = 0;
    logic [23:0] call_ret_addr = 0, call_target = 0;
    logic [9:0]  mem_addr;
    logic        mem_we, mem_re, pop_valid, pc_load, busy;
    logic [7:0]  mem_wdata, pop_data, sp_out, ext_out, actrl_out, mctrl_out;
    logic [7:0]  mem_rdata = 0;
    logic [23:0] pc_target;

    always #2 clk = ~clk;

    xstack_unit dut_i (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .call_req(call_req), .call_irq(call_irq),
        .call_ret_addr(call_ret_addr), .call_target(call_target), .ret_req(ret_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .pop_valid(pop_valid), .pop_data(pop_data),
        .pc_load(pc_load), .pc_target(pc_target), .busy(busy), .sp_out(sp_out),
        .ext_out(ext_out), .actrl_out(actrl_out), .mctrl_out(mctrl_out)
    );

    // bench-side stack memory with one-cycle read latency
    logic [7:0] ram [1024];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [7:0] sp_m = 8'd7, act_m = 8'd0, mct_m = 8'd0;
    logic [1:0] ext_m = 2'd0;
    logic [7:0] exp_mem [1024];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] eff_addr();
        return act_m[2] ? {ext_m, sp_m} : {2'b00, sp_m};
    endfunction

    task automatic m_inc();
        sp_m = sp_m + 8'd1;
        if (act_m[2] && sp_m == 8'h00) ext_m = ext_m + 2'd1;
    endtask

    task automatic m_dec();
        sp_m = sp_m - 8'd1;
        if (act_m[2] && sp_m == 8'hFF) ext_m = ext_m - 2'd1;
    endtask

    task automatic m_write(input logic [1:0] sel, input logic [7:0] d);
        case (sel)
            2'b00: sp_m = d;
            2'b01: ext_m = d[1:0];
            2'b10: begin act_m = d; if (d[2] && mct_m[7:6] == 2'b11) act_m[2] = 1'b0; end
            default: begin mct_m = d; if (act_m[2]) mct_m[7:6] = 2'b00; end
        endcase
    endtask

    task automatic chk_regs(input string req);
        chk(req, sp_out, sp_m);
        chk(req, ext_out, {6'b0, ext_m});
        chk(req, actrl_out, act_m);
        chk(req, mctrl_out, mct_m);
    endtask

    // all tasks start just after a falling edge
    task automatic op_push(input logic [7:0] d);
        logic [9:0] a;
        push_req = 1; push_data = d;
        #1;
        m_inc(); a = eff_addr();
        chk("R2 we", mem_we, 1); chk("R2 addr", mem_addr, a); chk("R2 data", mem_wdata, d);
        exp_mem[a] = d;
        @(negedge clk); push_req = 0;
        chk("R2 sp", sp_out, sp_m); chk("R3 ext", ext_out, {6'b0, ext_m});
    endtask

    task automatic op_pop();
        logic [9:0] a;
        pop_req = 1;
        #1;
        a = eff_addr();
        chk("R5 re", mem_re, 1); chk("R5 addr", mem_addr, a);
        m_dec();
        @(negedge clk); pop_req = 0;
        #1;
        chk("R5 valid", pop_valid, 1); chk("R5 data", pop_data, exp_mem[a]);
        chk("R5 sp", sp_out, sp_m); chk("R3 ext", ext_out, {6'b0, ext_m});
        @(negedge clk);
    endtask

    task automatic op_call(input logic [23:0] ra, input logic [23:0] tg, input logic irq, input logic noise);
        logic [9:0]  a;
        logic        fl;
        int          n;
        logic [23:0] exp_t;
        fl = act_m[1]; n = fl ? 3 : 2;
        exp_t = {(fl && !irq) ? tg[23:16] : 8'h00, tg[15:0]};
        for (int i = 0; i < n; i++) begin
            if (i == 0) begin
                call_req = 1; call_ret_addr = ra; call_target = tg; call_irq = irq;
                if (noise) begin
                    push_req = 1; pop_req = 1; push_data = 8'hEE;
                    reg_wr = 1; reg_sel = 2'b00; reg_wdata = 8'h55;
                end
            end
            #1;
            m_inc(); a = eff_addr();
            chk("R6 we", mem_we, 1); chk("R12 no read", mem_re, 0);
            chk("R6 addr", mem_addr, a); chk("R6 byte", mem_wdata, ra[8*i +: 8]);
            exp_mem[a] = ra[8*i +: 8];
            chk("R6 pc_load", pc_load, (i == n - 1));
            if (i == n - 1) chk("R7 target", pc_target, exp_t);
            if (i > 0) chk("R13 busy", busy, 1);
            @(negedge clk);
            call_req = 0;
        end
        push_req = 0; pop_req = 0; reg_wr = 0;
        chk("R13 sp", sp_out, sp_m); chk("R14 ext", ext_out, {6'b0, ext_m});
    endtask

    task automatic op_ret(input logic noise);
        logic [9:0] a;
        logic [7:0] b [3];
        logic       fl;
        int         n;
        logic [23:0] exp_pc;
        fl = act_m[1]; n = fl ? 3 : 2;
        for (int i = 0; i < n; i++) begin
            if (i == 0) begin
                ret_req = 1;
                if (noise) begin push_req = 1; pop_req = 1; push_data = 8'h77; end
            end
            #1;
            a = eff_addr();
            chk("R8 re", mem_re, 1); chk("R8 addr", mem_addr, a); chk("R12 no write", mem_we, 0);
            b[i] = exp_mem[a];
            m_dec();
            @(negedge clk);
            ret_req = 0;
        end
        push_req = 0; pop_req = 0;
        #1;
        exp_pc = fl ? {b[0], b[1], b[2]} : {8'h00, b[0], b[1]};
        chk("R8 pc_load", pc_load, 1); chk("R8 target", pc_target, exp_pc);
        @(negedge clk);
        chk("R8 sp", sp_out, sp_m); chk("R3 ext", ext_out, {6'b0, ext_m});
    endtask

    task automatic op_wr(input logic [1:0] sel, input logic [7:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
        m_write(sel, d);
        chk_regs("R9 regs");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin ram[i] = 8'h00; exp_mem[i] = 8'h00; end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp", sp_out, 8'd7); chk("R1 ext", ext_out, 0);
        chk("R1 amode", actrl_out, 0); chk("R1 mmode", mctrl_out, 0); chk("R1 busy", busy, 0);

        // R4 narrow mode wrap keeps extension
        op_push(8'h11); op_push(8'h22); op_pop(); op_pop();
        op_wr(2'b01, 8'h02);
        op_wr(2'b00, 8'hFF);
        op_push(8'h33);
        chk("R4 wrap sp", sp_out, 8'h00); chk("R4 ext held", ext_out, 8'h02);
        op_pop();
        chk("R4 ext after pop", ext_out, 8'h02);

        // R9 extension keeps only two bits
        op_wr(2'b01, 8'hFF);
        chk("R9 ext mask", ext_out, 8'h03);

        // R3 wide mode carry and borrow
        op_wr(2'b10, 8'h04);
        op_wr(2'b01, 8'h01); op_wr(2'b00, 8'hFE);
        op_push(8'hA1); op_push(8'hB2);
        chk("R3 carry ext", ext_out, 8'h02);
        op_pop();
        chk("R3 borrow ext", ext_out, 8'h01); chk("R3 borrow sp", sp_out, 8'hFF);
        op_wr(2'b01, 8'h03); op_wr(2'b00, 8'hFF);
        op_push(8'hC3);
        chk("R3 ext wraps", ext_out, 8'h00);
        op_pop();

        // R11 then R10 interlocks
        op_wr(2'b11, 8'hC0);
        chk("R11 blocked", mctrl_out, 8'h00);
        op_wr(2'b10, 8'h00);
        op_wr(2'b11, 8'hC0);
        op_wr(2'b10, 8'h06);
        chk("R10 blocked", actrl_out, 8'h02);
        op_wr(2'b11, 8'h00);
        op_wr(2'b10, 8'h06);

        // R6 R7 R8 flat calls
        op_call(24'h12_3456, 24'hAB_CDEF, 1'b0, 1'b0);
        op_call(24'h78_9ABC, 24'hFE_DCBA, 1'b1, 1'b0);
        op_ret(1'b0);
        op_ret(1'b0);
        // 16-bit calls and returns
        op_wr(2'b10, 8'h04);
        op_call(24'h00_BEEF, 24'h5A_1234, 1'b0, 1'b0);
        op_ret(1'b0);

        // R12 R13 R14: competing requests and writes
        op_call(24'h01_2345, 24'h00_4321, 1'b0, 1'b1);
        op_ret(1'b1);

        // R14: push with same-cycle mode write, wide at 0xFF
        op_wr(2'b00, 8'hFF); op_wr(2'b01, 8'h00);
        push_req = 1; push_data = 8'h5C; reg_wr = 1; reg_sel = 2'b10; reg_wdata = 8'h00;
        #1;
        m_inc();
        chk("R14 old mode addr", mem_addr, 10'h100);
        exp_mem[10'h100] = 8'h5C;
        @(negedge clk); push_req = 0; reg_wr = 0;
        chk("R14 mode kept", actrl_out, 8'h04); chk("R14 ext", ext_out, 8'h01);

        // constrained random traffic
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom % 12;
            if (r < 4)       op_push(8'($urandom));
            else if (r < 6)  op_pop();
            else if (r == 6) op_call(24'($urandom), 24'($urandom), 1'($urandom), 1'($urandom));
            else if (r == 7) op_ret(1'($urandom));
            else             op_wr(2'(r - 8), 8'($urandom));
        end
        chk_regs("R9 final");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule